// File: doc/BRIEF.md
# Power-On and System Reset Sequencer

This block turns three reset causes into the reset outputs of a small system-on-chip. The causes are an active-low power-on input, a watchdog reset event and a software reset request. A power-on reset captures the configuration strap pins and holds all three clock generators in reset. When the power-on input goes high again, the block releases the generators in a fixed order. It enables each generator's output only once that generator reports lock, or once its lock wait times out. It then holds the processor in reset for a programmed number of cycles, which by default corresponds to roughly 100 µs. It also emits a single-cycle pulse that clears the affected timer and watchdog register bits.

A watchdog event or a software request that arrives while the system runs causes a system reset. The processor reset and the active-low bus reset to peripheral agents are both asserted for a fixed minimum time. The clock generators, the strap register and the lock-timeout flags keep their state. The sequencer state is visible on a debug output.

Top module: `reset_seq_top`

## Requirements
- R1: While `por_n_in` is low, `pll_rst` is 3'b111, `pll_out_en` is 3'b000, `cpu_rst` is 1, `bus_rst_n` is 0, `lock_tmo` is 3'b000, `tmr_clr` is 0 and `dbg_state` is 0. These values take effect asynchronously.
- R2: `por_n_in` passes through a SYNC_STAGES-flop synchronizer. `tmr_clr` is high for exactly one cycle per power-on, in the first cycle of state 1.
- R3: Generator k is handled in state k+1, with generators taken in the order 0, 1, 2. Its `pll_rst[k]` bit drops one cycle after that state is entered. Its `pll_out_en[k]` bit rises at the clock edge where `pll_lock[k]` is sampled high while `pll_rst[k]` is already low, and the sequencer then moves to the next state.
- R4: If lock is not seen within LOCK_TMO cycles of entering a wait state, the sequencer moves on at the LOCK_TMO-th edge, enables the output anyway and sets bit k of `lock_tmo`. That bit stays set until the next power-on.
- R5: `cpu_rst` and `bus_rst_n` are released together, exactly CPU_DLY cycles after state 4 is entered. The state then becomes 5 (running).
- R6: A high `wdt_rst_evt` or `sw_rst_req` sampled in state 5 asserts `cpu_rst` and drops `bus_rst_n` at that edge, and enters state 6. Both stay asserted for SYS_HOLD cycles (default 16), after which the state returns to 5.
- R7: A watchdog or software reset leaves `pll_rst`, `pll_out_en`, `strap_q` and `lock_tmo` unchanged and does not pulse `tmr_clr`.
- R8: A software request sampled in any state other than 5 is ignored, and a request during state 6 does not lengthen that reset.
- R9: A watchdog event sampled in state 6 restarts the hold, so the release comes SYS_HOLD cycles after the last event.
- R10: `dbg_state` encodes the states as follows: 0 power-on hold, 1, 2 and 3 waiting for generators 0, 1 and 2, 4 processor delay, 5 running, 6 system reset.
- R11: `strap_q` takes `strap_in` on every clock edge while the synchronized power-on is low, and holds it from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n_in | input | 1 | Asynchronous active-low power-on reset |
| wdt_rst_evt | input | 1 | Watchdog reset event, synchronous |
| sw_rst_req | input | 1 | Software reset request, synchronous |
| strap_in | input | STRAP_W | Configuration strap pins |
| pll_lock | input | 3 | Lock indication of each clock generator |
| pll_rst | output | 3 | Active-high reset of each clock generator |
| pll_out_en | output | 3 | Output enable of each clock generator |
| lock_tmo | output | 3 | Sticky lock-timeout flag per generator |
| strap_q | output | STRAP_W | Captured strap value |
| cpu_rst | output | 1 | Active-high processor reset |
| bus_rst_n | output | 1 | Active-low reset to bus agents |
| tmr_clr | output | 1 | One-cycle clear pulse for timer/watchdog bits |
| dbg_state | output | 3 | Current sequencer state |

## Verification
The bench builds the block with SYNC_STAGES=2, LOCK_TMO=10, CPU_DLY=30, STRAP_W=6 and the default SYS_HOLD=16. With these values a complete power-on sequence fits in a few dozen cycles. This lets one run repeat the sequence several times. In one run generator 2 never locks, which forces the timeout path. A later power-on then shows that the sticky flags clear. The short delay also leaves room to place watchdog and software pulses at exact offsets inside the 16-cycle hold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   localparam int NUM_GEN = 3;

   typedef enum logic [2:0] {
      ST_POR_HOLD  = 3'd0,
      ST_GEN_WAIT0 = 3'd1,
      ST_GEN_WAIT1 = 3'd2,
      ST_GEN_WAIT2 = 3'd3,
      ST_CPU_DELAY = 3'd4,
      ST_RUN       = 3'd5,
      ST_SYS_RESET = 3'd6
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_sync: STAGES must be at least 2");
      end
   endgenerate

   // Asynchronous assertion, synchronous release of the power-on level
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_span.sv
module rstseq_span #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         clr,
   output logic [W-1:0] cnt_o
);
   generate
      if (W < 1) begin : g_bad_width
         $error("rstseq_span: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_o <= '0;
      end else if (clr) begin
         cnt_o <= '0;
      end else begin
         cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/rstseq_gen_gate.sv
module rstseq_gen_gate (
   input  logic clk,
   input  logic arst_n,
   input  logic active,
   input  logic lock_i,
   input  logic tmo_hit,
   output logic gen_rst,
   output logic gen_en,
   output logic tmo_flag,
   output logic adv
);
   logic lock_ok;

   // Lock only counts once this generator's reset has actually dropped
   assign lock_ok = lock_i && !gen_rst;
   assign adv     = active && (lock_ok || tmo_hit);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         gen_rst  <= 1'b1;
         gen_en   <= 1'b0;
         tmo_flag <= 1'b0;
      end else if (active) begin
         gen_rst <= 1'b0;
         if (lock_ok || tmo_hit) begin
            gen_en <= 1'b1;
         end
         if (tmo_hit && !lock_ok) begin
            tmo_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/reset_seq_top.sv
module reset_seq_top
   import rstseq_pkg::*;
#(
   parameter int STRAP_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_TMO    = 4096,
   parameter int CPU_DLY     = 25000,
   parameter int SYS_HOLD    = 16
) (
   input  logic               clk,
   input  logic               por_n_in,
   input  logic               wdt_rst_evt,
   input  logic               sw_rst_req,
   input  logic [STRAP_W-1:0] strap_in,
   input  logic [NUM_GEN-1:0] pll_lock,
   output logic [NUM_GEN-1:0] pll_rst,
   output logic [NUM_GEN-1:0] pll_out_en,
   output logic [NUM_GEN-1:0] lock_tmo,
   output logic [STRAP_W-1:0] strap_q,
   output logic               cpu_rst,
   output logic               bus_rst_n,
   output logic               tmr_clr,
   output logic [2:0]         dbg_state
);
   localparam int SPAN_MAX = max3(LOCK_TMO, CPU_DLY, SYS_HOLD);
   localparam int CNT_W    = $clog2(SPAN_MAX + 1);
   localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TMO - 1);
   localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(CPU_DLY - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(SYS_HOLD - 1);

   generate
      if (STRAP_W < 1) begin : g_bad_strap
         $error("reset_seq_top: STRAP_W must be positive");
      end
      if (LOCK_TMO < 2) begin : g_bad_lock
         $error("reset_seq_top: LOCK_TMO must be at least 2");
      end
      if (CPU_DLY < 1) begin : g_bad_dly
         $error("reset_seq_top: CPU_DLY must be positive");
      end
      if (SYS_HOLD < 1) begin : g_bad_hold
         $error("reset_seq_top: SYS_HOLD must be positive");
      end
   endgenerate

   logic               por_sync;
   seq_state_e         st_q, st_d;
   logic               span_clr;
   logic [CNT_W-1:0]   span_q;
   logic [NUM_GEN-1:0] gen_adv;
   logic               tmo_hit;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (por_n_in),
      .sync_o (por_sync)
   );

   rstseq_span #(.W(CNT_W)) u_span (
      .clk    (clk),
      .arst_n (por_n_in),
      .clr    (span_clr),
      .cnt_o  (span_q)
   );

   assign tmo_hit = (span_q == LOCK_LAST);

   // One gate per clock generator, each active in its own wait state
   for (genvar k = 0; k < NUM_GEN; k++) begin : g_gen
      localparam seq_state_e GATE_ST = seq_state_e'(3'(k + 1));
      rstseq_gen_gate u_gate (
         .clk      (clk),
         .arst_n   (por_n_in),
         .active   (st_q == GATE_ST),
         .lock_i   (pll_lock[k]),
         .tmo_hit  (tmo_hit),
         .gen_rst  (pll_rst[k]),
         .gen_en   (pll_out_en[k]),
         .tmo_flag (lock_tmo[k]),
         .adv      (gen_adv[k])
      );
   end

   // Strap capture: follows the pins while power-on is held
   always_ff @(posedge clk) begin
      if (!por_sync) begin
         strap_q <= strap_in;
      end
   end

   always_comb begin
      st_d     = st_q;
      span_clr = 1'b0;
      unique case (st_q)
         ST_POR_HOLD:  if (por_sync)   st_d = ST_GEN_WAIT0;
         ST_GEN_WAIT0: if (gen_adv[0]) st_d = ST_GEN_WAIT1;
         ST_GEN_WAIT1: if (gen_adv[1]) st_d = ST_GEN_WAIT2;
         ST_GEN_WAIT2: if (gen_adv[2]) st_d = ST_CPU_DELAY;
         ST_CPU_DELAY: if (span_q == DLY_LAST) st_d = ST_RUN;
         ST_RUN:       if (wdt_rst_evt || sw_rst_req) st_d = ST_SYS_RESET;
         ST_SYS_RESET: begin
            if (wdt_rst_evt) begin
               span_clr = 1'b1;
            end else if (span_q == HOLD_LAST) begin
               st_d = ST_RUN;
            end
         end
         default:      st_d = ST_POR_HOLD;
      endcase
      if (st_d != st_q) begin
         span_clr = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n_in) begin
      if (!por_n_in) begin
         st_q <= ST_POR_HOLD;
      end else begin
         st_q <= st_d;
      end
   end

   // Processor and bus resets: asserted asynchronously, released on the clock
   always_ff @(posedge clk or negedge por_n_in) begin
      if (!por_n_in) begin
         cpu_rst   <= 1'b1;
         bus_rst_n <= 1'b0;
      end else if (st_d == ST_RUN && st_q != ST_RUN) begin
         cpu_rst   <= 1'b0;
         bus_rst_n <= 1'b1;
      end else if (st_d == ST_SYS_RESET && st_q == ST_RUN) begin
         cpu_rst   <= 1'b1;
         bus_rst_n <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n_in) begin
      if (!por_n_in) begin
         tmr_clr <= 1'b0;
      end else begin
         tmr_clr <= (st_q == ST_POR_HOLD) && por_sync;
      end
   end

   assign dbg_state = st_q;
endmodule

// File: rtl/reset_seq_chk.sv
module reset_seq_chk #(
   parameter int STRAP_W = 8
) (
   input logic               clk,
   input logic               por_n_in,
   input logic [2:0]         pll_rst,
   input logic [2:0]         pll_out_en,
   input logic [2:0]         lock_tmo,
   input logic [STRAP_W-1:0] strap_q,
   input logic               cpu_rst,
   input logic               bus_rst_n,
   input logic               tmr_clr,
   input logic [2:0]         dbg_state
);
   for (genvar k = 0; k < 3; k++) begin : g_k
      // R3
      en_after_rst_chk: assert property (@(posedge clk) disable iff (!por_n_in)
         pll_out_en[k] |-> !pll_rst[k]);
      // R4
      tmo_sticky_chk: assert property (@(posedge clk) disable iff (!por_n_in)
         lock_tmo[k] |=> lock_tmo[k]);
      if (k > 0) begin : g_ord
         // R3
         gen_order_chk: assert property (@(posedge clk) disable iff (!por_n_in)
            $rose(pll_out_en[k]) |-> pll_out_en[k-1]);
      end
   end

   // R2
   clr_single_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      tmr_clr |=> !tmr_clr);
   // R2
   clr_place_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      tmr_clr |-> dbg_state == 3'd1);
   // R6
   rst_pair_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      cpu_rst != bus_rst_n);
   // R7
   gen_keep_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      dbg_state == 3'd6 |-> $stable(pll_out_en) && $stable(pll_rst));
   // R11
   strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      (dbg_state != 3'd0 && $past(dbg_state) != 3'd0) |-> $stable(strap_q));
   // R10
   state_range_chk: assert property (@(posedge clk) disable iff (!por_n_in)
      dbg_state <= 3'd6);
endmodule

bind reset_seq_top reset_seq_chk #(.STRAP_W(STRAP_W)) u_chk (.*);

// File: tb/reset_seq_top_tb_top.sv
`timescale 1ns/1ps
module reset_seq_top_tb_top;
   localparam int SW  = 6;
   localparam int SYN = 2;
   localparam int LTO = 10;
   localparam int DLY = 30;
   localparam int HLD = 16;
   localparam int NEVER = 1000000;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          wdt = 1'b0;
   logic          sw = 1'b0;
   logic [SW-1:0] strap = '0;
   logic [2:0]    lock = '0;
   logic [2:0]    pll_rst, pll_out_en, lock_tmo;
   logic [SW-1:0] strap_q;
   logic          cpu_rst, bus_rst_n, tmr_clr;
   logic [2:0]    dbg_state;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   reset_seq_top #(.STRAP_W(SW), .SYNC_STAGES(SYN), .LOCK_TMO(LTO),
                   .CPU_DLY(DLY), .SYS_HOLD(HLD)) dut_i (
      .clk(clk), .por_n_in(por_n), .wdt_rst_evt(wdt), .sw_rst_req(sw),
      .strap_in(strap), .pll_lock(lock), .pll_rst(pll_rst),
      .pll_out_en(pll_out_en), .lock_tmo(lock_tmo), .strap_q(strap_q),
      .cpu_rst(cpu_rst), .bus_rst_n(bus_rst_n), .tmr_clr(tmr_clr),
      .dbg_state(dbg_state));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int            m_age, m_st, m_left;
   bit [2:0]      m_prst, m_pen, m_tmo;
   bit            m_cpu, m_busn, m_clr, m_strap_ok;
   logic [SW-1:0] m_strap;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_age = 0; m_st = 0; m_left = 0;
         m_prst = 3'b111; m_pen = 0; m_tmo = 0;
         m_cpu = 1; m_busn = 0; m_clr = 0;
         if (clk) begin m_strap = strap; m_strap_ok = 1; end
      end else begin
         bit ps;
         ps = (m_age >= SYN);
         if (!ps) begin m_strap = strap; m_strap_ok = 1; end
         if (m_age < SYN) m_age++;
         m_clr = (m_st == 0) && ps;
         case (m_st)
            0: if (ps) begin m_st = 1; m_left = LTO; end
            1, 2, 3: begin
               int g; bit locked;
               g = m_st - 1;
               locked = lock[g] && !m_prst[g];
               m_left--;
               m_prst[g] = 0;
               if (locked || m_left == 0) begin
                  m_pen[g] = 1;
                  if (!locked) m_tmo[g] = 1;
                  m_st++;
                  m_left = (m_st == 4) ? DLY : LTO;
               end
            end
            4: begin
               m_left--;
               if (m_left == 0) begin m_st = 5; m_cpu = 0; m_busn = 1; end
            end
            5: if (wdt || sw) begin m_st = 6; m_left = HLD; m_cpu = 1; m_busn = 0; end
            6: begin
               if (wdt) m_left = HLD;
               else begin
                  m_left--;
                  if (m_left == 0) begin m_st = 5; m_cpu = 0; m_busn = 1; end
               end
            end
            default: m_st = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   int low_len = 0, last_low = 0, clr_cnt = 0, dly_cnt = 0, en_idx = 0;
   int en_order [3];
   logic [2:0] pen_prev = '0;
   always @(negedge clk) begin
      if (!done) begin
         check(dbg_state == 3'(m_st), "R10 state", dbg_state, m_st);
         check(pll_rst == m_prst && pll_out_en == m_pen, "R3 generators",
               {pll_rst, pll_out_en}, {m_prst, m_pen});
         check(lock_tmo == m_tmo, "R4 lock_tmo", lock_tmo, m_tmo);
         check(cpu_rst == m_cpu && bus_rst_n == m_busn, "R5/R6 resets",
               {cpu_rst, bus_rst_n}, {m_cpu, m_busn});
         check(tmr_clr == m_clr, "R2 tmr_clr", tmr_clr, m_clr);
         if (m_strap_ok) check(strap_q == m_strap, "R11 strap", strap_q, m_strap);
         if (bus_rst_n) begin
            if (low_len != 0) last_low = low_len;
            low_len = 0;
         end else low_len++;
         if (tmr_clr) clr_cnt++;
         if (dbg_state == 3'd4) dly_cnt++;
         for (int k = 0; k < 3; k++)
            if (pll_out_en[k] && !pen_prev[k]) begin
               en_order[k] = en_idx; en_idx++;
            end
         pen_prev = pll_out_en;
      end
   end

   // ---------------- clock generator lock model ----------------
   int lat [3] = '{3, 5, 2};
   int run [3] = '{0, 0, 0};
   always @(negedge clk) begin
      #2;
      for (int k = 0; k < 3; k++) begin
         if (pll_rst[k]) begin run[k] = 0; lock[k] = 1'b0; end
         else begin run[k]++; if (run[k] >= lat[k]) lock[k] = 1'b1; end
      end
   end

   task automatic pulse_sw();
      @(negedge clk); #1 sw = 1'b1;
      @(negedge clk); #1 sw = 1'b0;
   endtask

   task automatic pulse_wdt();
      @(negedge clk); #1 wdt = 1'b1;
      @(negedge clk); #1 wdt = 1'b0;
   endtask

   task automatic wait_run();
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (dbg_state == 3'd5) break;
      end
      #1;
   endtask

   task automatic power_on(input logic [SW-1:0] sv);
      @(negedge clk); #1 por_n = 1'b0; strap = sv;
      clr_cnt = 0; dly_cnt = 0; en_idx = 0;
      repeat (4) @(negedge clk);
      #1 strap = sv ^ {SW{1'b1}};
      @(negedge clk); #1 strap = sv;
      @(negedge clk); #1 por_n = 1'b1;
   endtask

   initial begin
      // Scenario A: generator 2 never locks
      lat[2] = NEVER;
      repeat (3) @(negedge clk);
      // R1: values during power-on hold
      check(pll_rst == 3'b111 && pll_out_en == 3'b000, "R1 gens", {pll_rst, pll_out_en}, 6'b111000);
      check(cpu_rst == 1'b1 && bus_rst_n == 1'b0 && dbg_state == 3'd0, "R1 resets",
            {cpu_rst, bus_rst_n, dbg_state}, 5'b10000);
      power_on(6'h2d);
      wait_run();
      check(clr_cnt == 1, "R2 clear pulse count", clr_cnt, 1);
      check(en_order[0] == 0 && en_order[1] == 1 && en_order[2] == 2, "R3 order",
            en_order[0] * 100 + en_order[1] * 10 + en_order[2], 12);
      check(lock_tmo == 3'b100, "R4 timeout flag", lock_tmo, 3'b100);
      check(dly_cnt == DLY, "R5 processor delay", dly_cnt, DLY);
      check(strap_q == 6'h2d, "R11 captured strap", strap_q, 6'h2d);
      // R11: strap pins move while running
      strap = 6'h11;
      repeat (3) @(negedge clk);
      check(strap_q == 6'h2d, "R11 strap held", strap_q, 6'h2d);

      // R6/R7: software reset
      pulse_sw();
      check(dbg_state == 3'd6, "R6 system reset state", dbg_state, 6);
      wait_run();
      check(last_low == HLD, "R6 hold length", last_low, HLD);
      check(pll_out_en == 3'b111 && pll_rst == 3'b000, "R7 generators kept",
            {pll_rst, pll_out_en}, 6'b000111);
      check(lock_tmo == 3'b100 && strap_q == 6'h2d, "R7 flags and strap kept",
            {lock_tmo, strap_q}, {3'b100, 6'h2d});
      check(clr_cnt == 1, "R7 no clear pulse", clr_cnt, 1);

      // R8: software request during a reset is ignored
      pulse_sw();
      repeat (4) @(negedge clk);
      pulse_sw();
      wait_run();
      check(last_low == HLD, "R8 hold not extended", last_low, HLD);

      // R9: watchdog restarts the hold
      pulse_wdt();
      repeat (3) @(negedge clk);
      pulse_wdt();
      wait_run();
      check(last_low == HLD + 5, "R9 hold restarted", last_low, HLD + 5);

      // Scenario B: fresh power-on, all generators lock
      lat[2] = 4;
      power_on(6'h1a);
      repeat (2) @(negedge clk);
      // R8: software request during the power-on sequence
      #1 sw = 1'b1;
      @(negedge clk); #1 sw = 1'b0;
      wait_run();
      check(lock_tmo == 3'b000, "R4 flags cleared by power-on", lock_tmo, 0);
      check(clr_cnt == 1, "R2 pulse per power-on", clr_cnt, 1);
      check(strap_q == 6'h1a, "R11 new strap", strap_q, 6'h1a);
      check(dly_cnt == DLY, "R8 power-on not disturbed", dly_cnt, DLY);

      repeat (5) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule